// File: doc/BRIEF.md
# Tagged Multi-History Branch Direction Predictor

This block predicts whether a conditional branch is taken. It has two kinds of table. One base table has no tags and is indexed by the branch address alone. Several tagged tables are indexed and tagged by hashing the branch address with a slice of the global outcome history. Each tagged table uses a longer slice than the one before it. On the predict port the block takes an address and returns a direction. It also returns which component supplied that direction (the provider) and which component would have been used next (the alternate).

The caller keeps the provider and alternate identities. Once the branch resolves, the caller passes them back on the update port together with the address and the real outcome. In that cycle the block trains the provider's counter and adjusts the usefulness bit. It also trains a global confidence counter, which decides when a newly allocated entry should be bypassed. On a misprediction it claims a free entry in a longer-history table. The history register shifts only on an update. An update must therefore use the same history that its prediction used.

The block is not a state machine: its only sequential state is the tables, the history register and the confidence counter.

Top module: `tage_predictor`

## Requirements
- R1: After reset the state is as follows. Every base counter is 2'b01. Every tagged entry holds tag 0, counter 3 and usefulness 0. The confidence counter is 0 and the history is 0.
- R2: The history has 16 bits, and bit 0 is the newest outcome. Tagged table k (k = 1..3) uses history length 4·2^(k-1). Folding a history of length L to width W XORs history bit j (j < L) into bit j mod W. Table k has 16 entries. Its index is pc[3:0] ^ pc[7:4] ^ fold(L, 4). Its 6-bit tag is pc[15:10] ^ fold(L, 6). The base table has 32 entries and is indexed by pc[4:0].
- R3: The provider is the highest-numbered tagged table whose stored tag equals the computed tag. It is reported as k, or as 0 for the base table when no tagged table hits.
- R4: The alternate is the next lower hitting tagged table. When there is no such table it is 0 (the base table). When the provider is 0, the alternate is also 0.
- R5: Each component predicts from its counter. A tagged counter predicts taken when it is 4 or more. A base counter predicts taken when it is 2 or more. The final direction is the provider's, except in one case. If the provider is tagged and weak (counter 3 or 4), and the confidence counter is 8 or more, the alternate's direction is used.
- R6: With upd_valid high, only the provider's counter is trained, toward the outcome. A tagged counter saturates at 0 and 7, and a base counter at 0 and 3.
- R7: When the provider is tagged and its direction differs from the alternate's, its usefulness bit becomes 1 if the provider was correct and 0 otherwise.
- R8: The confidence counter is 4 bits and saturates at 0 and 15. It changes only when the provider is tagged and weak and its direction differs from the alternate's. It increments when the alternate was correct and decrements otherwise.
- R9: When the final direction was wrong, a new entry is claimed. It goes in the lowest-numbered table above the provider whose entry at the update index has usefulness 0. That entry receives the computed tag, counter 4 if taken or 3 if not, and usefulness 0.
- R10: When the final direction was wrong and no table above the provider has a free entry, the usefulness bit of each of those entries is cleared and nothing is claimed.
- R11: Each update shifts the history left by one and inserts the outcome at bit 0.
- R12: With upd_valid low, no table, counter or history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | 16 | Branch address to predict |
| pred_taken | output | 1 | Final predicted direction |
| pred_provider | output | 2 | Provider component (0 base, k tagged table k) |
| pred_alt | output | 2 | Alternate component (same encoding) |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_provider | input | 2 | Provider identity saved from the prediction |
| upd_alt | input | 2 | Alternate identity saved from the prediction |

## Verification
Several properties are checked by assertions on every clock. The alternate must be ordered below the provider. The history must shift on each update and hold otherwise. The confidence counter must neither wrap nor move while idle.

The remaining behaviours can be seen only through predictions made after chosen sequences of outcomes. These are provider choice across table hits, the weak-entry bypass, counter saturation, usefulness changes, and claiming versus clearing. The bench shows them by checking every prediction against a reference model, in scenarios with per-address taken biases, alternating patterns, history-correlated outcomes and idle cycles carrying junk on the update inputs.

// File: rtl/tage_pkg.sv
package tage_pkg;

    localparam logic [2:0] TCTR_WEAK_NT = 3'd3;
    localparam logic [2:0] TCTR_WEAK_T  = 3'd4;
    localparam logic [1:0] BCTR_INIT    = 2'd1;

    function automatic logic [2:0] tctr_next(input logic [2:0] c, input logic t);
        if (t) return (c == 3'd7) ? c : c + 3'd1;
        return (c == 3'd0) ? c : c - 3'd1;
    endfunction

    function automatic logic [1:0] bctr_next(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic [3:0] conf_next(input logic [3:0] c, input logic up);
        if (up) return (c == 4'd15) ? c : c + 4'd1;
        return (c == 4'd0) ? c : c - 4'd1;
    endfunction

    function automatic logic tctr_weak(input logic [2:0] c);
        return (c == TCTR_WEAK_NT) || (c == TCTR_WEAK_T);
    endfunction

endpackage

// File: rtl/tage_base_tbl.sv
module tage_base_tbl #(
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] p_idx,
    output logic [1:0]        p_ctr,
    input  logic [BASE_W-1:0] u_idx,
    output logic [1:0]        u_ctr,
    input  logic              w_en,
    input  logic [BASE_W-1:0] w_idx,
    input  logic [1:0]        w_ctr
);
    import tage_pkg::*;

    localparam int ENTRIES = 1 << BASE_W;

    logic [1:0] ctr_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= BCTR_INIT;
        end else if (w_en) begin
            ctr_q[w_idx] <= w_ctr;
        end
    end

    assign p_ctr = ctr_q[p_idx];
    assign u_ctr = ctr_q[u_idx];

endmodule

// File: rtl/tage_tag_tbl.sv
module tage_tag_tbl #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] p_idx,
    input  logic [TAG_W-1:0] p_tag,
    output logic             p_hit,
    output logic [2:0]       p_ctr,
    input  logic [IDX_W-1:0] u_idx,
    output logic [2:0]       u_ctr,
    output logic [TAG_W-1:0] u_tag,
    output logic             u_use,
    input  logic             w_en,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  logic [2:0]       w_ctr,
    input  logic             w_use
);
    import tage_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [2:0]       ctr_q [ENTRIES];
    logic             use_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e] <= '0;
                ctr_q[e] <= TCTR_WEAK_NT;
                use_q[e] <= 1'b0;
            end
        end else if (w_en) begin
            tag_q[w_idx] <= w_tag;
            ctr_q[w_idx] <= w_ctr;
            use_q[w_idx] <= w_use;
        end
    end

    assign p_hit = (tag_q[p_idx] == p_tag);
    assign p_ctr = ctr_q[p_idx];
    assign u_ctr = ctr_q[u_idx];
    assign u_tag = tag_q[u_idx];
    assign u_use = use_q[u_idx];

endmodule

// File: rtl/tage_predictor.sv
module tage_predictor #(
    parameter int PC_W       = 16,
    parameter int BASE_W     = 5,
    parameter int NUM_TAGGED = 3,
    parameter int IDX_W      = 4,
    parameter int TAG_W      = 6,
    parameter int MIN_HIST   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [PC_W-1:0]                   pred_pc,
    output logic                              pred_taken,
    output logic [$clog2(NUM_TAGGED+1)-1:0]   pred_provider,
    output logic [$clog2(NUM_TAGGED+1)-1:0]   pred_alt,
    input  logic                              upd_valid,
    input  logic [PC_W-1:0]                   upd_pc,
    input  logic                              upd_taken,
    input  logic [$clog2(NUM_TAGGED+1)-1:0]   upd_provider,
    input  logic [$clog2(NUM_TAGGED+1)-1:0]   upd_alt
);
    import tage_pkg::*;

    localparam int PROV_W = $clog2(NUM_TAGGED + 1);
    localparam int GHR_W  = MIN_HIST << (NUM_TAGGED - 1);

    logic [GHR_W-1:0] ghr;
    logic [3:0]       alt_ctr;

    function automatic logic [IDX_W-1:0] fold_idx(input logic [GHR_W-1:0] h, input int len);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int j = 0; j < GHR_W; j++) if (j < len) r[j % IDX_W] ^= h[j];
        return r;
    endfunction

    function automatic logic [TAG_W-1:0] fold_tag(input logic [GHR_W-1:0] h, input int len);
        logic [TAG_W-1:0] r;
        r = '0;
        for (int j = 0; j < GHR_W; j++) if (j < len) r[j % TAG_W] ^= h[j];
        return r;
    endfunction

    // Per-table lookup signals (p_: predict side, u_: update side, w_: write)
    logic [IDX_W-1:0] p_idx [NUM_TAGGED];
    logic [TAG_W-1:0] p_tag [NUM_TAGGED];
    logic             p_hit [NUM_TAGGED];
    logic [2:0]       p_ctr [NUM_TAGGED];
    logic [IDX_W-1:0] u_idx [NUM_TAGGED];
    logic [TAG_W-1:0] u_tagc [NUM_TAGGED];
    logic [TAG_W-1:0] u_tagm [NUM_TAGGED];
    logic [2:0]       u_ctr [NUM_TAGGED];
    logic             u_use [NUM_TAGGED];
    logic             w_en  [NUM_TAGGED];
    logic [TAG_W-1:0] w_tag [NUM_TAGGED];
    logic [2:0]       w_ctr [NUM_TAGGED];
    logic             w_use [NUM_TAGGED];

    logic [1:0] pb_ctr, ub_ctr, wb_ctr;
    logic       wb_en;

    tage_base_tbl #(.BASE_W(BASE_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .p_idx (pred_pc[BASE_W-1:0]),
        .p_ctr (pb_ctr),
        .u_idx (upd_pc[BASE_W-1:0]),
        .u_ctr (ub_ctr),
        .w_en  (wb_en),
        .w_idx (upd_pc[BASE_W-1:0]),
        .w_ctr (wb_ctr)
    );

    for (genvar g = 0; g < NUM_TAGGED; g++) begin : g_tbl
        localparam int LEN = MIN_HIST << g;

        assign p_idx[g]  = pred_pc[IDX_W-1:0] ^ pred_pc[2*IDX_W-1:IDX_W] ^ fold_idx(ghr, LEN);
        assign p_tag[g]  = pred_pc[PC_W-1 -: TAG_W] ^ fold_tag(ghr, LEN);
        assign u_idx[g]  = upd_pc[IDX_W-1:0] ^ upd_pc[2*IDX_W-1:IDX_W] ^ fold_idx(ghr, LEN);
        assign u_tagc[g] = upd_pc[PC_W-1 -: TAG_W] ^ fold_tag(ghr, LEN);

        tage_tag_tbl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .p_idx (p_idx[g]),
            .p_tag (p_tag[g]),
            .p_hit (p_hit[g]),
            .p_ctr (p_ctr[g]),
            .u_idx (u_idx[g]),
            .u_ctr (u_ctr[g]),
            .u_tag (u_tagm[g]),
            .u_use (u_use[g]),
            .w_en  (w_en[g]),
            .w_idx (u_idx[g]),
            .w_tag (w_tag[g]),
            .w_ctr (w_ctr[g]),
            .w_use (w_use[g])
        );
    end

    // Predict side: provider and alternate selection
    logic [PROV_W-1:0] prov_p, alt_p;
    logic              pdir_p, adir_p, weak_p;

    always_comb begin
        prov_p = '0;
        alt_p  = '0;
        for (int k = 0; k < NUM_TAGGED; k++) begin
            if (p_hit[k]) begin
                alt_p  = prov_p;
                prov_p = PROV_W'(k + 1);
            end
        end
        pdir_p = pb_ctr[1];
        adir_p = pb_ctr[1];
        weak_p = 1'b0;
        for (int k = 0; k < NUM_TAGGED; k++) begin
            if (prov_p == PROV_W'(k + 1)) begin
                pdir_p = p_ctr[k][2];
                weak_p = tctr_weak(p_ctr[k]);
            end
            if (alt_p == PROV_W'(k + 1)) adir_p = p_ctr[k][2];
        end
    end

    assign pred_provider = prov_p;
    assign pred_alt      = alt_p;
    assign pred_taken    = (weak_p && alt_ctr[3]) ? adir_p : pdir_p;

    // Update side: re-read components named by the saved identities
    logic pdir_u, adir_u, weak_u, final_u, miss_u, free_any;
    logic [NUM_TAGGED-1:0] alloc_hot;

    always_comb begin
        pdir_u = ub_ctr[1];
        adir_u = ub_ctr[1];
        weak_u = 1'b0;
        for (int k = 0; k < NUM_TAGGED; k++) begin
            if (upd_provider == PROV_W'(k + 1)) begin
                pdir_u = u_ctr[k][2];
                weak_u = tctr_weak(u_ctr[k]);
            end
            if (upd_alt == PROV_W'(k + 1)) adir_u = u_ctr[k][2];
        end
        final_u = (weak_u && alt_ctr[3]) ? adir_u : pdir_u;
        miss_u  = (final_u != upd_taken);

        free_any  = 1'b0;
        alloc_hot = '0;
        for (int k = 0; k < NUM_TAGGED; k++) begin
            if (PROV_W'(k + 1) > upd_provider && !u_use[k] && !free_any) begin
                free_any     = 1'b1;
                alloc_hot[k] = 1'b1;
            end
        end

        wb_en  = upd_valid && (upd_provider == '0);
        wb_ctr = bctr_next(ub_ctr, upd_taken);

        for (int k = 0; k < NUM_TAGGED; k++) begin
            w_en[k]  = 1'b0;
            w_tag[k] = u_tagm[k];
            w_ctr[k] = u_ctr[k];
            w_use[k] = u_use[k];
            if (upd_valid) begin
                if (upd_provider == PROV_W'(k + 1)) begin
                    w_en[k]  = 1'b1;
                    w_ctr[k] = tctr_next(u_ctr[k], upd_taken);
                    if (pdir_u != adir_u) w_use[k] = (pdir_u == upd_taken);
                end else if (miss_u && PROV_W'(k + 1) > upd_provider) begin
                    if (alloc_hot[k]) begin
                        w_en[k]  = 1'b1;
                        w_tag[k] = u_tagc[k];
                        w_ctr[k] = upd_taken ? TCTR_WEAK_T : TCTR_WEAK_NT;
                        w_use[k] = 1'b0;
                    end else if (!free_any) begin
                        w_en[k]  = 1'b1;
                        w_use[k] = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghr     <= '0;
            alt_ctr <= '0;
        end else if (upd_valid) begin
            ghr <= {ghr[GHR_W-2:0], upd_taken};
            if (weak_u && (pdir_u != adir_u))
                alt_ctr <= conf_next(alt_ctr, adir_u == upd_taken);
        end
    end

endmodule

// File: rtl/tage_chk.sv
module tage_chk #(
    parameter int GHR_W  = 16,
    parameter int PROV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PROV_W-1:0] pred_provider,
    input logic [PROV_W-1:0] pred_alt,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [GHR_W-1:0]  ghr,
    input logic [3:0]        alt_ctr
);
    // R4
    alt_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_provider != '0) |-> (pred_alt < pred_provider));

    // R4
    alt_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_provider == '0) |-> (pred_alt == '0));

    // R11
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr[0] == $past(upd_taken)) && (ghr[GHR_W-1:1] == $past(ghr[GHR_W-2:0])));

    // R12
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr));

    // R12
    conf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(alt_ctr));

    // R8
    conf_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_ctr == 4'd15) |=> (alt_ctr != 4'd0));

    // R8
    conf_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_ctr == 4'd0) |=> (alt_ctr != 4'd15));

endmodule

bind tage_predictor tage_chk #(.GHR_W(GHR_W), .PROV_W(PROV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_provider (pred_provider),
    .pred_alt      (pred_alt),
    .upd_valid     (upd_valid),
    .upd_taken     (upd_taken),
    .ghr           (ghr),
    .alt_ctr       (alt_ctr)
);

// File: tb/tb_tage_predictor.sv
`timescale 1ns/1ps
module tb_tage_predictor;

    localparam int NT = 3;
    localparam int IW = 4;
    localparam int TW = 6;
    localparam int BW = 5;
    localparam int GW = 16;
    localparam int MH = 4;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pred_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_provider, pred_alt;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_provider = '0, upd_alt = '0;

    always #(CLK_NS / 2.0) clk = ~clk;

    tage_predictor dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pred_pc       (pred_pc),
        .pred_taken    (pred_taken),
        .pred_provider (pred_provider),
        .pred_alt      (pred_alt),
        .upd_valid     (upd_valid),
        .upd_pc        (upd_pc),
        .upd_taken     (upd_taken),
        .upd_provider  (upd_provider),
        .upd_alt       (upd_alt)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    logic [1:0]    m_base [1 << BW];
    logic [2:0]    m_ctr  [NT][1 << IW];
    logic [TW-1:0] m_tag  [NT][1 << IW];
    logic          m_use  [NT][1 << IW];
    logic [GW-1:0] m_ghr;
    int            m_conf;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_fold(input logic [GW-1:0] h, input int len, input int w);
        int r = 0;
        for (int j = 0; j < len; j++) if (h[j]) r = r ^ (1 << (j % w));
        return r;
    endfunction

    function automatic int m_idx(input int k, input logic [15:0] pc);
        return int'(pc[3:0]) ^ int'(pc[7:4]) ^ m_fold(m_ghr, MH << k, IW);
    endfunction

    function automatic int m_tagc(input int k, input logic [15:0] pc);
        return int'(pc[15:10]) ^ m_fold(m_ghr, MH << k, TW);
    endfunction

    function automatic bit m_dir(input int comp, input logic [15:0] pc);
        if (comp == 0) return m_base[pc[BW-1:0]][1];
        return m_ctr[comp-1][m_idx(comp-1, pc)][2];
    endfunction

    function automatic bit m_weak(input int comp, input logic [15:0] pc);
        logic [2:0] c;
        if (comp == 0) return 1'b0;
        c = m_ctr[comp-1][m_idx(comp-1, pc)];
        return (c == 3'd3) || (c == 3'd4);
    endfunction

    function automatic void m_predict(input logic [15:0] pc, output int prov, output int alt, output bit dir);
        prov = 0;
        alt  = 0;
        for (int k = 0; k < NT; k++) begin
            if (int'(m_tag[k][m_idx(k, pc)]) == m_tagc(k, pc)) begin
                alt  = prov;
                prov = k + 1;
            end
        end
        dir = (m_weak(prov, pc) && m_conf >= 8) ? m_dir(alt, pc) : m_dir(prov, pc);
    endfunction

    function automatic string m_update(input logic [15:0] pc, input bit t, input int prov, input int alt);
        string ev = "R6";
        bit pd = m_dir(prov, pc);
        bit ad = m_dir(alt, pc);
        bit wk = m_weak(prov, pc);
        bit fin = (wk && m_conf >= 8) ? ad : pd;
        int idx [NT];
        int tg  [NT];
        int sel = -1;
        for (int k = 0; k < NT; k++) begin
            idx[k] = m_idx(k, pc);
            tg[k]  = m_tagc(k, pc);
        end
        if (prov == 0) begin
            logic [1:0] b = m_base[pc[BW-1:0]];
            if (t && b != 2'd3) b = b + 2'd1;
            if (!t && b != 2'd0) b = b - 2'd1;
            m_base[pc[BW-1:0]] = b;
        end else begin
            logic [2:0] c = m_ctr[prov-1][idx[prov-1]];
            if (t && c != 3'd7) c = c + 3'd1;
            if (!t && c != 3'd0) c = c - 3'd1;
            m_ctr[prov-1][idx[prov-1]] = c;
            if (pd != ad) begin
                m_use[prov-1][idx[prov-1]] = (pd == t);
                ev = "R7";
            end
            if (wk && pd != ad) begin
                if (ad == t) m_conf = (m_conf == 15) ? 15 : m_conf + 1;
                else         m_conf = (m_conf == 0) ? 0 : m_conf - 1;
                ev = "R8";
            end
        end
        if (fin != t && prov < NT) begin
            for (int k = prov; k < NT; k++)
                if (sel < 0 && !m_use[k][idx[k]]) sel = k;
            if (sel >= 0) begin
                m_tag[sel][idx[sel]] = TW'(tg[sel]);
                m_ctr[sel][idx[sel]] = t ? 3'd4 : 3'd3;
                m_use[sel][idx[sel]] = 1'b0;
                ev = "R9";
            end else begin
                for (int k = prov; k < NT; k++) m_use[k][idx[k]] = 1'b0;
                ev = "R10";
            end
        end
        m_ghr = {m_ghr[GW-2:0], t};
        return ev;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < (1 << BW); i++) m_base[i] = 2'd1;
        for (int k = 0; k < NT; k++)
            for (int i = 0; i < (1 << IW); i++) begin
                m_ctr[k][i] = 3'd3;
                m_tag[k][i] = '0;
                m_use[k][i] = 1'b0;
            end
        m_ghr  = '0;
        m_conf = 0;
    endfunction

    string last_ev = "R1";

    task automatic compare_pred(input logic [15:0] pc, output int prov, output int alt);
        bit dir;
        m_predict(pc, prov, alt, dir);
        check(int'(pred_provider) == prov, {"R2/R3 provider after ", last_ev},
              int'(pred_provider), prov);
        check(int'(pred_alt) == alt, {"R4 alternate after ", last_ev}, int'(pred_alt), alt);
        check(pred_taken == dir, {"R5 direction after ", last_ev}, int'(pred_taken), int'(dir));
    endtask

    task automatic step(input logic [15:0] pc, input bit t);
        int prov, alt;
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc   = pc;
        #1;
        compare_pred(pc, prov, alt);
        upd_valid    = 1'b1;
        upd_pc       = pc;
        upd_taken    = t;
        upd_provider = 2'(prov);
        upd_alt      = 2'(alt);
        @(posedge clk);
        last_ev = m_update(pc, t, prov, alt);
        #1 upd_valid = 1'b0;
    endtask

    task automatic idle_junk();
        @(negedge clk);
        upd_valid    = 1'b0;
        upd_pc       = 16'($urandom);
        upd_taken    = 1'($urandom);
        upd_provider = 2'($urandom);
        upd_alt      = 2'($urandom);
        @(posedge clk);
        last_ev = "R12";
    endtask

    logic [15:0] pcs [8];

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int prov, alt;
        void'($urandom(32'd20190320));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: tag 0 at zero history hits every table; counters weak not-taken
        pred_pc = 16'h0000;
        #1;
        check(pred_provider == 2'd3, "R1 reset provider", int'(pred_provider), 3);
        check(pred_alt == 2'd2, "R1 reset alternate", int'(pred_alt), 2);
        check(pred_taken == 1'b0, "R1 reset direction", int'(pred_taken), 0);
        pred_pc = 16'hFC00;
        #1;
        check(pred_provider == 2'd0, "R1 reset no-hit provider", int'(pred_provider), 0);
        check(pred_taken == 1'b0, "R1 reset base direction", int'(pred_taken), 0);

        // R6: saturate a base counter and a tagged counter
        for (int i = 0; i < 6; i++) step(16'hFC01, 1'b1);
        for (int i = 0; i < 6; i++) step(16'hFC01, 1'b0);
        for (int i = 0; i < 10; i++) step(16'h0000, 1'b1);

        // R9/R10: mispredictions on a fresh address force claiming then clearing
        for (int i = 0; i < 12; i++) step(16'h4440, i[0]);

        // R12: junk on the update inputs while idle
        for (int i = 0; i < 4; i++) idle_junk();
        @(negedge clk);
        pred_pc = 16'h4440;
        #1;
        compare_pred(16'h4440, prov, alt);

        // Mixed random traffic
        for (int i = 0; i < 8; i++) pcs[i] = 16'($urandom);
        for (int n = 0; n < 3000; n++) begin
            int  s = int'($urandom_range(0, 7));
            bit  t;
            if ($urandom_range(0, 7) == 0) begin
                idle_junk();
                continue;
            end
            unique case (s % 4)
                0: t = 1'b1;
                1: t = n[0];
                2: t = m_ghr[2] ^ m_ghr[5];
                default: t = 1'($urandom);
            endcase
            step(pcs[s], t);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule